// File: doc/BRIEF.md
# Free-running timer with edge-triggered capture and byte-safe readout

The block counts every clock in a 16-bit free-running counter. It watches one external capture pin and, on the edge polarity chosen by software, copies the current count into a 16-bit capture register and raises a capture flag. Software reads the result over an 8-bit register bus, one byte at a time. An interlock keeps the two bytes it gets from the same capture event.

A control register holds the edge-select bit and four interrupt enables: one for the capture flag and three for flags that sit outside this block (two compare events and a counter overflow). Those three come in as inputs. The interrupt output is high while any flag is set and its enable is on. Reset clears only the control register and the counter. A captured value, the capture flag and the read interlock survive reset.

Top module: `tmr_capture`

## Requirements
- R1: `count_o` is 0 while `rst_ni` is low, advances by exactly one on each rising clock edge after reset, and wraps from 0xFFFF to 0x0000.
- R2: The control register is at address 0x10 and resets to 0x00. Bit 7 enables the capture interrupt, bit 6 the first compare interrupt, bit 5 the second compare interrupt, bit 4 the overflow interrupt, and bit 1 selects the edge. All other bits are not writable and read 0, so a write of 0xFF reads back 0xF2.
- R3: With bit 1 of the control register set, a rising edge on `cap_pin_i` captures and a falling edge is ignored. With bit 1 clear, a falling edge captures and a rising edge is ignored. An ignored edge leaves both the capture register and the flag unchanged.
- R4: A capture stores the value `count_o` holds just before the third rising clock edge after the pin changes. The pin passes through a two-flop synchronizer before the edge is detected.
- R5: The capture high byte is at 0x12 and the low byte at 0x13. A read of 0x12 blocks all later captures until 0x13 is read. A capture edge that arrives while captures are blocked is dropped: it is not held over, the register keeps its value and the flag is not set. The first valid edge after the low-byte read is captured.
- R6: A read of 0x13 on its own never blocks captures. An edge detected in the same cycle as a low-byte read is captured.
- R7: `cap_flag_o` is set by each capture that is taken and cleared by a high cycle on `cap_flag_clr_i`. When a capture and a clear fall in the same cycle, the flag ends up set.
- R8: `irq_o` is the OR of four terms: capture flag AND bit 7, `oc0_flag_i` AND bit 6, `oc1_flag_i` AND bit 5, and `ovf_flag_i` AND bit 4.
- R9: Reset clears the control register and the counter only. The capture register and the capture flag keep their values through a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (control register and counter) |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| bus_addr_i | input | 8 | Register address |
| bus_wr_i | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rd_i | input | 1 | Read strobe; the interlock side effects happen on the rising edge |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational; unmapped addresses read 0) |
| cap_flag_clr_i | input | 1 | Clears the capture flag |
| oc0_flag_i | input | 1 | First compare flag, from outside the block |
| oc1_flag_i | input | 1 | Second compare flag, from outside the block |
| ovf_flag_i | input | 1 | Overflow flag, from outside the block |
| count_o | output | 16 | Free-running counter value |
| cap_flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench fires a capture edge between the high-byte and low-byte reads. A design with a missing or leaky interlock would return the two bytes of the captured value from different events, or would set the flag. It also fires an edge in the very cycle of a low-byte read, and another in the cycle of a flag clear. A design that blocks on the low byte, or lets the clear win, would drop that capture. Random captures with random polarity catch an inverted or ignored edge-select bit, and an off-by-one in the synchronizer latency shows up as a wrong captured count. A reset taken after a capture catches a design that clears the capture register or the flag along with the counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 2 * DATA_W;

  localparam logic [7:0] ADDR_CTRL   = 8'h10;
  localparam logic [7:0] ADDR_CAP_HI = 8'h12;
  localparam logic [7:0] ADDR_CAP_LO = 8'h13;

  localparam int unsigned BIT_EN_CAP = 7;
  localparam int unsigned BIT_EN_OC0 = 6;
  localparam int unsigned BIT_EN_OC1 = 5;
  localparam int unsigned BIT_EN_OVF = 4;
  localparam int unsigned BIT_EDGE   = 1;

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(
      (1 << BIT_EN_CAP) | (1 << BIT_EN_OC0) | (1 << BIT_EN_OC1) |
      (1 << BIT_EN_OVF) | (1 << BIT_EDGE));
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_N-1];
  end

  // edge when the settled level moves to the selected polarity
  assign edge_o = (sync_q[SYNC_N-1] != prev_q) && (sync_q[SYNC_N-1] == rise_sel_i);

  AST_EDGE_POL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> ($past(pin_i, 2) == rise_sel_i)) else $error("edge polarity"); // R3
endmodule

// File: rtl/tmr_cap_latch.sv
module tmr_cap_latch
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cap_q;
  logic             lock_q;
  logic             flag_q;
  logic             accept;

  // a high-byte read in flight also blocks, so the byte it returns stays paired
  assign accept = edge_i && !rd_hi_i && (!lock_q || rd_lo_i);

  // capture state is deliberately outside reset
  always_ff @(posedge clk_i) begin
    if (accept) cap_q <= cnt_i;
    if (rd_hi_i)      lock_q <= 1'b1;
    else if (rd_lo_i) lock_q <= 1'b0;
    flag_q <= accept || (flag_q && !flag_clr_i);
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !rd_lo_i) |=> $stable(cap_q)) else $error("capture while locked"); // R5
  AST_CAP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !lock_q && !rd_hi_i) |=> (cap_q == $past(cnt_i))) else $error("capture value"); // R4
  AST_LO_NO_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && rd_lo_i) |=> flag_q) else $error("low read blocked"); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !lock_q && !rd_hi_i && flag_clr_i) |=> flag_q) else $error("clear beat set"); // R7
endmodule

// File: rtl/tmr_ctrl_irq.sv
module tmr_ctrl_irq
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_flag_i,
  input  logic              oc0_flag_i,
  input  logic              oc1_flag_i,
  input  logic              ovf_flag_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              rise_sel_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [3:0]        flags;
  logic [3:0]        enables;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i & CTRL_MASK;
  end

  assign flags   = {cap_flag_i, oc0_flag_i, oc1_flag_i, ovf_flag_i};
  assign enables = {ctrl_q[BIT_EN_CAP], ctrl_q[BIT_EN_OC0],
                    ctrl_q[BIT_EN_OC1], ctrl_q[BIT_EN_OVF]};
  assign irq_o      = |(flags & enables);
  assign ctrl_o     = ctrl_q;
  assign rise_sel_o = ctrl_q[BIT_EDGE];

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7:4] == 4'b0) |-> !irq_o) else $error("irq while masked"); // R8
  AST_IRQ_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_i && ctrl_o[7]) |-> irq_o) else $error("capture irq lost"); // R8
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_pin_i,
  input  logic [7:0]        bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              cap_flag_clr_i,
  input  logic              oc0_flag_i,
  input  logic              oc1_flag_i,
  input  logic              ovf_flag_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              cap_flag_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cap;
  logic [DATA_W-1:0] ctrl;
  logic              rise_sel;
  logic              cap_edge;
  logic              rd_hi;
  logic              rd_lo;
  logic              ctrl_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end
  assign count_o = cnt_q;

  assign rd_hi   = bus_rd_i && (bus_addr_i == ADDR_CAP_HI);
  assign rd_lo   = bus_rd_i && (bus_addr_i == ADDR_CAP_LO);
  assign ctrl_wr = bus_wr_i && (bus_addr_i == ADDR_CTRL);

  tmr_pin_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (cap_pin_i),
    .rise_sel_i (rise_sel),
    .edge_o     (cap_edge)
  );

  tmr_cap_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_i     (cap_edge),
    .cnt_i      (cnt_q),
    .rd_hi_i    (rd_hi),
    .rd_lo_i    (rd_lo),
    .flag_clr_i (cap_flag_clr_i),
    .cap_o      (cap),
    .flag_o     (cap_flag_o)
  );

  tmr_ctrl_irq u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_wr),
    .wdata_i    (bus_wdata_i),
    .cap_flag_i (cap_flag_o),
    .oc0_flag_i (oc0_flag_i),
    .oc1_flag_i (oc1_flag_i),
    .ovf_flag_i (ovf_flag_i),
    .ctrl_o     (ctrl),
    .rise_sel_o (rise_sel),
    .irq_o      (irq_o)
  );

  always_comb begin
    case (bus_addr_i)
      ADDR_CTRL:   bus_rdata_o = ctrl;
      ADDR_CAP_HI: bus_rdata_o = cap[CNT_W-1:DATA_W];
      ADDR_CAP_LO: bus_rdata_o = cap[DATA_W-1:0];
      default:     bus_rdata_o = '0;
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == CNT_W'($past(count_o) + 1'b1))) else $error("counter step"); // R1
endmodule

// File: tb/tmr_capture_tb.sv
module tmr_capture_tb;
  localparam int CLK_NS = 10;
  localparam logic [7:0] A_CTRL = 8'h10, A_HI = 8'h12, A_LO = 8'h13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        clr = 1'b0;
  logic        oc0 = 1'b0, oc1 = 1'b0, ovf = 1'b0;
  logic [15:0] count;
  logic        flag;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_NS/2) clk = ~clk;

  tmr_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cap_pin_i(pin), .bus_addr_i(addr),
    .bus_wr_i(wr_en), .bus_wdata_i(wdata), .bus_rd_i(rd_en), .bus_rdata_o(rdata),
    .cap_flag_clr_i(clr), .oc0_flag_i(oc0), .oc1_flag_i(oc1), .ovf_flag_i(ovf),
    .count_o(count), .cap_flag_o(flag), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic irq_model(logic [3:0] en, logic f, logic a, logic b, logic c);
    return (f & en[3]) | (a & en[2]) | (b & en[1]) | (c & en[0]);
  endfunction

  task automatic bus_rd(logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_cap(output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(A_HI, h);
    bus_rd(A_LO, l);
    v = {h, l};
  endtask

  // side: 0 none, 1 low-byte read in the edge cycle, 2 flag clear in the edge cycle
  task automatic pin_to(logic v, int side, output logic [15:0] c);
    pin = v;
    @(negedge clk);
    @(negedge clk);
    c = count;
    if (side == 1) begin addr = A_LO; rd_en = 1'b1; end
    if (side == 2) clr = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] c, v, old, c2;
    logic [7:0]  d;
    logic        pol, fl;
    logic [3:0]  en;
    void'($urandom(32'h5eed_0017));

    // reset state
    repeat (3) @(negedge clk);
    check("R1 count in reset", count, 16'h0);
    bus_rd(A_CTRL, d);
    check("R2 ctrl reset", d, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after release", count, 16'h1);
    c = count; repeat (7) @(negedge clk);
    check("R1 count step", count, 16'(c + 7));
    bus_rd(A_LO, d);
    clear_flag();

    // control register
    bus_wr(A_CTRL, 8'hFF); bus_rd(A_CTRL, d);
    check("R2 writable bits", d, 8'hF2);
    bus_wr(A_CTRL, 8'h00); bus_rd(A_CTRL, d);
    check("R2 clear", d, 8'h00);

    // falling polarity
    pin_to(1'b1, 0, c);
    check("R3 rising ignored when falling selected", flag, 1'b0);
    pin_to(1'b0, 0, c);
    check("R7 flag set", flag, 1'b1);
    read_cap(v);
    check("R4 falling capture value", v, c);
    old = v;
    clear_flag();
    check("R7 flag cleared", flag, 1'b0);

    // rising polarity
    bus_wr(A_CTRL, 8'h02);
    pin_to(1'b1, 0, c);
    read_cap(v);
    check("R3 rising capture value", v, c);
    old = v; clear_flag();
    pin_to(1'b0, 0, c);
    check("R3 falling ignored flag", flag, 1'b0);
    read_cap(v);
    check("R3 falling ignored value", v, old);

    // edge between high and low reads
    bus_rd(A_HI, d);
    check("R5 high byte", d, old[15:8]);
    pin_to(1'b1, 0, c);
    check("R5 blocked flag", flag, 1'b0);
    bus_rd(A_LO, d);
    check("R5 low byte coherent", d, old[7:0]);
    read_cap(v);
    check("R5 blocked value", v, old);
    pin_to(1'b0, 0, c);
    pin_to(1'b1, 0, c);
    read_cap(v);
    check("R5 capture after low read", v, c);
    clear_flag();

    // low read alone and low read in the edge cycle
    bus_rd(A_LO, d);
    pin_to(1'b0, 0, c);
    pin_to(1'b1, 0, c);
    check("R6 low read alone flag", flag, 1'b1);
    read_cap(v);
    check("R6 low read alone value", v, c);
    clear_flag();
    pin_to(1'b0, 0, c);
    bus_rd(A_HI, d);
    pin_to(1'b1, 1, c);
    check("R6 same-cycle low read flag", flag, 1'b1);
    read_cap(v);
    check("R6 same-cycle low read value", v, c);

    // clear in the capture cycle
    clear_flag();
    pin_to(1'b0, 0, c);
    pin_to(1'b1, 2, c);
    check("R7 set wins over clear", flag, 1'b1);
    clear_flag();
    check("R7 clear", flag, 1'b0);

    // interrupt gating
    fl = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (i == 8) begin
        pin_to(1'b0, 0, c);
        pin_to(1'b1, 0, c);
        fl = 1'b1;
      end
      en = 4'($urandom);
      oc0 = 1'($urandom); oc1 = 1'($urandom); ovf = 1'($urandom);
      bus_wr(A_CTRL, {en, 4'b0010});
      check("R8 irq gating", irq, irq_model(en, fl, oc0, oc1, ovf));
    end
    oc0 = 1'b0; oc1 = 1'b0; ovf = 1'b0;
    bus_rd(A_LO, d);
    clear_flag();

    // random polarity and timing
    read_cap(old);
    for (int i = 0; i < 24; i++) begin
      pol = 1'($urandom);
      bus_wr(A_CTRL, {6'b0, pol, 1'b0});
      repeat (int'($urandom % 5)) @(negedge clk);
      pin_to(~pin, 0, c);
      if (pin == pol) begin
        check("R3 random accepted flag", flag, 1'b1);
        old = c;
      end else begin
        check("R3 random ignored flag", flag, 1'b0);
      end
      read_cap(v);
      check("R4 random capture value", v, old);
      clear_flag();
    end

    // reset keeps capture state
    bus_wr(A_CTRL, 8'h00);
    if (pin == 1'b0) pin_to(1'b1, 0, c);
    pin_to(1'b0, 0, c);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 count restarted", count, 16'h1);
    check("R9 flag kept", flag, 1'b1);
    bus_rd(A_CTRL, d);
    check("R9 ctrl cleared", d, 8'h00);
    read_cap(v);
    check("R9 capture kept", v, c);

    // wrap
    while (count != 16'hFFFF) @(negedge clk);
    @(negedge clk);
    check("R1 wrap", count, 16'h0);
    c2 = count; @(negedge clk);
    check("R1 after wrap", count, 16'(c2 + 1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule